// File: doc/BRIEF.md
# Storage Access Protection Checker

This block decides whether a single storage access may go ahead. It applies two rules. The first is a guard on the lowest part of storage: when switched on, it rejects stores into the first 512 bytes. The second is a comparison of the access key against the 4-bit key of the addressed block, with a fetch-protect bit deciding whether mismatched fetches may proceed. Address translation, the key array and interruption handling sit outside. The requester supplies the addresses, the key data and the enable bit with each request.

An ordinary request returns either an allow or a protection-exception flag. A test request asks whether the block could be fetched and stored. It returns a 2-bit condition code with three possible outcomes. A two-state controller accepts a request in `ST_IDLE` and moves to `ST_RESP` (transition `ACCEPT`). In `ST_RESP` it presents the registered result for exactly one cycle and then returns to `ST_IDLE` (transition `RELEASE`). It accepts no new request while in `ST_RESP`.

Top module: `stor_prot_chk`

## Requirements
- R1: `req_ready` is high in `ST_IDLE`. A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. `rsp_valid` is then high during the following cycle only. `req_ready` is low during that cycle, and the block is back in `ST_IDLE` after it.
- R2: During and after reset, `req_ready` is 1 and `rsp_valid`, `rsp_allow`, `rsp_prot_exc`, `rsp_test` and `rsp_cc` are 0. Whenever `rsp_valid` is 0, the other response outputs are also 0. An asynchronous reset during a response cancels it.
- R3: A fetch (`req_store`=0) is allowed when the keys match or when `fetch_prot` is 0. Otherwise it yields a protection exception.
- R4: A store (`req_store`=1) is allowed only when the keys match and the low-address guard does not block it. Otherwise it yields a protection exception.
- R5: An access key of 0 matches every storage key, for both fetches and stores.
- R6: With `ctl_lowprot_en`=1, a store whose guard address is below 512 is blocked even when the keys match or the access key is 0. Address 511 is blocked and address 512 is not. With `ctl_lowprot_en`=0, the guard blocks nothing.
- R7: The guard address is `req_laddr` when `req_virt`=1 (the address before translation). It is `req_paddr` when `req_virt`=0.
- R8: Source classes are encoded in `req_src` as follows: 0 program operand, 1 page-entry invalidation operand, 2 direct-read operand, 3 hardware interruption/timer/logout/status store, 4 channel input data, 5 initial load or status save, 6 and 7 reserved. Classes 3, 4 and 5 are exempt from the guard. All others are subject to it.
- R9: Fetches are never blocked by the low-address guard.
- R10: A test request (`req_test`=1) reports `rsp_cc` as 0 when both fetch and store are permitted, 1 when only fetch is permitted, and 2 when neither is. Code 3 never appears. The store evaluation includes the guard for the given source class. `rsp_allow` and `rsp_prot_exc` stay 0 on test responses.
- R11: On an ordinary response, exactly one of `rsp_allow` and `rsp_prot_exc` is 1, and `rsp_cc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_test | input | 1 | 1 = test request, 0 = ordinary access |
| req_store | input | 1 | 1 = store, 0 = fetch |
| req_virt | input | 1 | 1 = address is translated; guard uses `req_laddr` |
| req_laddr | input | ADDR_W | Logical address before translation |
| req_paddr | input | ADDR_W | Address as presented to storage |
| req_src | input | 3 | Access-source class (encoding in R8) |
| acc_key | input | KEY_W | Access key |
| stor_key | input | KEY_W | Storage key of the addressed block |
| fetch_prot | input | 1 | Fetch-protect bit of the addressed block |
| ctl_lowprot_en | input | 1 | Low-address guard enable (control register 0, bit 3 counted from the MSB) |
| rsp_valid | output | 1 | Result strobe |
| rsp_allow | output | 1 | Ordinary access allowed |
| rsp_prot_exc | output | 1 | Ordinary access raises protection exception |
| rsp_test | output | 1 | Response belongs to a test request |
| rsp_cc | output | 2 | Test condition code (encoding in R10) |

## Verification
Each result is due in the cycle after the accepting rising edge, because exactly one register stage lies between the request inputs and the response outputs. The bench therefore drives a request on a falling edge and lets the next rising edge accept it. It samples the response at the falling edge that follows, then samples once more a cycle later to confirm that the strobe has dropped and `req_ready` has returned. Reset is checked both while held and after an asynchronous assertion in the middle of a response, where the outputs must clear without waiting for a clock edge.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [2:0] {
        SRC_PROG   = 3'd0,
        SRC_PGINV  = 3'd1,
        SRC_RDDIR  = 3'd2,
        SRC_HWINT  = 3'd3,
        SRC_CHDATA = 3'd4,
        SRC_LOADST = 3'd5,
        SRC_RSV6   = 3'd6,
        SRC_RSV7   = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        CC_FULL       = 2'd0,
        CC_FETCH_ONLY = 2'd1,
        CC_NONE       = 2'd2,
        CC_RSV        = 2'd3
    } cc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } st_e;

    localparam logic [7:0] DEF_EXEMPT_MASK = 8'b0011_1000;

endpackage

// File: rtl/spc_low_guard.sv
module spc_low_guard #(
    parameter int         ADDR_W      = 24,
    parameter int         LOW_LIMIT   = 512,
    parameter logic [7:0] EXEMPT_MASK = spc_pkg::DEF_EXEMPT_MASK
) (
    input  logic              en,
    input  logic              virt,
    input  logic [ADDR_W-1:0] laddr,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [2:0]        src,
    output logic              blocks
);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(LOW_LIMIT);

    logic [ADDR_W-1:0] gaddr;
    logic              in_low;
    logic              exempt;

    // pre-translation address whenever translation is active
    assign gaddr  = virt ? laddr : paddr;
    assign exempt = EXEMPT_MASK[src];

    generate
        if (LOW_LIMIT <= 0) begin : g_no_range
            assign in_low = 1'b0;
        end else begin : g_range
            assign in_low = (gaddr < LIMIT_A);
        end
    endgenerate

    assign blocks = en & in_low & ~exempt;
endmodule

// File: rtl/spc_key_eval.sv
module spc_key_eval #(
    parameter int KEY_W         = 4,
    parameter bit MASTER_KEY_EN = 1'b1
) (
    input  logic [KEY_W-1:0] acc_key,
    input  logic [KEY_W-1:0] stor_key,
    input  logic             fetch_prot,
    output logic             key_ok,
    output logic             fetch_ok
);
    logic exact;
    logic master;

    assign exact = (acc_key == stor_key);

    generate
        if (MASTER_KEY_EN) begin : g_master
            assign master = ~|acc_key;
        end else begin : g_no_master
            assign master = 1'b0;
        end
    endgenerate

    assign key_ok   = exact | master;
    assign fetch_ok = key_ok | ~fetch_prot;
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
    import spc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_test,
    input  logic       req_store,
    input  logic       key_ok,
    input  logic       fetch_ok,
    input  logic       guard_blk,
    output logic       req_ready,
    output logic       rsp_valid,
    output logic       rsp_allow,
    output logic       rsp_prot_exc,
    output logic       rsp_test,
    output logic [1:0] rsp_cc
);
    st_e  state_q, state_d;
    logic accept;
    logic store_ok;
    logic allow_d;
    cc_e  cc_d;

    logic allow_q, exc_q, test_q;
    cc_e  cc_q;

    assign accept   = req_valid & (state_q == ST_IDLE);
    assign store_ok = key_ok & ~guard_blk;

    always_comb begin
        if (store_ok)      cc_d = CC_FULL;
        else if (fetch_ok) cc_d = CC_FETCH_ONLY;
        else               cc_d = CC_NONE;
        allow_d = req_store ? store_ok : fetch_ok;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            allow_q <= 1'b0;
            exc_q   <= 1'b0;
            test_q  <= 1'b0;
            cc_q    <= CC_FULL;
        end else if (accept) begin
            test_q  <= req_test;
            allow_q <= ~req_test & allow_d;
            exc_q   <= ~req_test & ~allow_d;
            cc_q    <= req_test ? cc_d : CC_FULL;
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        rsp_valid    = 1'b0;
        rsp_allow    = 1'b0;
        rsp_prot_exc = 1'b0;
        rsp_test     = 1'b0;
        rsp_cc       = 2'd0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: begin
                rsp_valid    = 1'b1;
                rsp_allow    = allow_q;
                rsp_prot_exc = exc_q;
                rsp_test     = test_q;
                rsp_cc       = cc_q;
            end
            default: req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/stor_prot_chk.sv
module stor_prot_chk #(
    parameter int         ADDR_W        = 24,
    parameter int         KEY_W         = 4,
    parameter int         LOW_LIMIT     = 512,
    parameter bit         MASTER_KEY_EN = 1'b1,
    parameter logic [7:0] EXEMPT_MASK   = spc_pkg::DEF_EXEMPT_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_test,
    input  logic              req_store,
    input  logic              req_virt,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic [ADDR_W-1:0] req_paddr,
    input  logic [2:0]        req_src,
    input  logic [KEY_W-1:0]  acc_key,
    input  logic [KEY_W-1:0]  stor_key,
    input  logic              fetch_prot,
    input  logic              ctl_lowprot_en,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_prot_exc,
    output logic              rsp_test,
    output logic [1:0]        rsp_cc
);
    logic guard_blk;
    logic key_ok;
    logic fetch_ok;

    spc_low_guard #(
        .ADDR_W     (ADDR_W),
        .LOW_LIMIT  (LOW_LIMIT),
        .EXEMPT_MASK(EXEMPT_MASK)
    ) guard_i (
        .en    (ctl_lowprot_en),
        .virt  (req_virt),
        .laddr (req_laddr),
        .paddr (req_paddr),
        .src   (req_src),
        .blocks(guard_blk)
    );

    spc_key_eval #(
        .KEY_W        (KEY_W),
        .MASTER_KEY_EN(MASTER_KEY_EN)
    ) key_i (
        .acc_key   (acc_key),
        .stor_key  (stor_key),
        .fetch_prot(fetch_prot),
        .key_ok    (key_ok),
        .fetch_ok  (fetch_ok)
    );

    spc_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_test    (req_test),
        .req_store   (req_store),
        .key_ok      (key_ok),
        .fetch_ok    (fetch_ok),
        .guard_blk   (guard_blk),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_allow   (rsp_allow),
        .rsp_prot_exc(rsp_prot_exc),
        .rsp_test    (rsp_test),
        .rsp_cc      (rsp_cc)
    );
endmodule

// File: rtl/spc_chk.sv
module spc_chk #(
    parameter int         ADDR_W      = 24,
    parameter int         KEY_W       = 4,
    parameter int         LOW_LIMIT   = 512,
    parameter logic [7:0] EXEMPT_MASK = spc_pkg::DEF_EXEMPT_MASK
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_test,
    input logic              req_store,
    input logic              req_virt,
    input logic [ADDR_W-1:0] req_laddr,
    input logic [ADDR_W-1:0] req_paddr,
    input logic [2:0]        req_src,
    input logic [KEY_W-1:0]  acc_key,
    input logic              ctl_lowprot_en,
    input logic              rsp_valid,
    input logic              rsp_allow,
    input logic              rsp_prot_exc,
    input logic              rsp_test,
    input logic [1:0]        rsp_cc
);
    logic              acc;
    logic [ADDR_W-1:0] ga;
    assign acc = req_valid & req_ready;
    assign ga  = req_virt ? req_laddr : req_paddr;

    // R1
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    // R1
    rsp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R1
    ready_low_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R2
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_allow && !rsp_prot_exc && !rsp_test && rsp_cc == 2'd0));
    // R11
    ordinary_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_test) |-> ((rsp_allow ^ rsp_prot_exc) && rsp_cc == 2'd0));
    // R10
    test_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_test) |-> (!rsp_allow && !rsp_prot_exc && rsp_cc != 2'd3));
    // R6
    low_store_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_test && req_store && ctl_lowprot_en
         && ga < ADDR_W'(LOW_LIMIT) && !EXEMPT_MASK[req_src]) |=> rsp_prot_exc);
    // R5
    key_zero_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_test && !req_store && acc_key == '0) |=> rsp_allow);
endmodule

bind stor_prot_chk spc_chk #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .LOW_LIMIT(LOW_LIMIT), .EXEMPT_MASK(EXEMPT_MASK)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_test(req_test), .req_store(req_store), .req_virt(req_virt),
    .req_laddr(req_laddr), .req_paddr(req_paddr), .req_src(req_src),
    .acc_key(acc_key), .ctl_lowprot_en(ctl_lowprot_en), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_prot_exc(rsp_prot_exc), .rsp_test(rsp_test),
    .rsp_cc(rsp_cc)
);

// File: tb/stor_prot_chk_tb_top.sv
`timescale 1ns/1ps
module stor_prot_chk_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_test = 1'b0, req_store = 1'b0, req_virt = 1'b0;
    logic [23:0] req_laddr = '0, req_paddr = '0;
    logic [2:0]  req_src = '0;
    logic [3:0]  acc_key = '0, stor_key = '0;
    logic        fetch_prot = 1'b0, ctl_lowprot_en = 1'b0;
    logic        req_ready, rsp_valid, rsp_allow, rsp_prot_exc, rsp_test;
    logic [1:0]  rsp_cc;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    stor_prot_chk dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_test(req_test), .req_store(req_store), .req_virt(req_virt),
        .req_laddr(req_laddr), .req_paddr(req_paddr), .req_src(req_src),
        .acc_key(acc_key), .stor_key(stor_key), .fetch_prot(fetch_prot),
        .ctl_lowprot_en(ctl_lowprot_en), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_prot_exc(rsp_prot_exc), .rsp_test(rsp_test), .rsp_cc(rsp_cc)
    );

    typedef struct packed {
        logic [23:0] la;
        logic [23:0] pa;
        logic        virt;
        logic        st;
        logic        tst;
        logic [2:0]  src;
        logic [3:0]  ak;
        logic [3:0]  sk;
        logic        fp;
        logic        en;
        logic        ex_allow;
        logic [1:0]  ex_cc;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VT [NV] = '{
        '{24'h4000, 24'h4000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5, 4'd5, 1'b1, 1'b1, 1'b1, 2'd0}, // R3 match
        '{24'h4000, 24'h4000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5, 4'd6, 1'b0, 1'b1, 1'b1, 2'd0}, // R3 no fetch-prot
        '{24'h4000, 24'h4000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5, 4'd6, 1'b1, 1'b1, 1'b0, 2'd0}, // R3 protected
        '{24'h1000, 24'h1000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd5, 4'd5, 1'b0, 1'b1, 1'b1, 2'd0}, // R4 match
        '{24'h1000, 24'h1000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd5, 4'd6, 1'b0, 1'b1, 1'b0, 2'd0}, // R4 mismatch
        '{24'h2000, 24'h2000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 4'd9, 1'b1, 1'b1, 1'b1, 2'd0}, // R5 store
        '{24'h2000, 24'h2000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 4'd9, 1'b1, 1'b1, 1'b1, 2'd0}, // R5 fetch
        '{24'h01FF, 24'h01FF, 1'b1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 2'd0}, // R6 511 blocked
        '{24'h01FF, 24'h01FF, 1'b1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 2'd0}, // R6 disabled
        '{24'h0200, 24'h0200, 1'b1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b1, 2'd0}, // R6 512 free
        '{24'h0100, 24'h8000, 1'b1, 1'b1, 1'b0, 3'd0, 4'd5, 4'd5, 1'b0, 1'b1, 1'b0, 2'd0}, // R7 logical low
        '{24'h8000, 24'h0100, 1'b1, 1'b1, 1'b0, 3'd0, 4'd5, 4'd5, 1'b0, 1'b1, 1'b1, 2'd0}, // R7 logical high
        '{24'h8000, 24'h0100, 1'b0, 1'b1, 1'b0, 3'd0, 4'd5, 4'd5, 1'b0, 1'b1, 1'b0, 2'd0}, // R7 real low
        '{24'h0010, 24'h0010, 1'b0, 1'b1, 1'b0, 3'd3, 4'd5, 4'd5, 1'b0, 1'b1, 1'b1, 2'd0}, // R8 class 3
        '{24'h0010, 24'h0010, 1'b0, 1'b1, 1'b0, 3'd4, 4'd5, 4'd5, 1'b0, 1'b1, 1'b1, 2'd0}, // R8 class 4
        '{24'h0010, 24'h0010, 1'b0, 1'b1, 1'b0, 3'd5, 4'd5, 4'd5, 1'b0, 1'b1, 1'b1, 2'd0}, // R8 class 5
        '{24'h0010, 24'h0010, 1'b0, 1'b1, 1'b0, 3'd1, 4'd5, 4'd5, 1'b0, 1'b1, 1'b0, 2'd0}, // R8 class 1
        '{24'h0010, 24'h0010, 1'b0, 1'b1, 1'b0, 3'd2, 4'd5, 4'd5, 1'b0, 1'b1, 1'b0, 2'd0}, // R8 class 2
        '{24'h0010, 24'h0010, 1'b0, 1'b1, 1'b0, 3'd6, 4'd5, 4'd5, 1'b0, 1'b1, 1'b0, 2'd0}, // R8 class 6
        '{24'h0010, 24'h0010, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5, 4'd5, 1'b1, 1'b1, 1'b1, 2'd0}, // R9 low fetch
        '{24'h4000, 24'h4000, 1'b0, 1'b0, 1'b1, 3'd0, 4'd5, 4'd5, 1'b1, 1'b1, 1'b0, 2'd0}, // R10 cc0
        '{24'h4000, 24'h4000, 1'b0, 1'b0, 1'b1, 3'd0, 4'd5, 4'd6, 1'b0, 1'b1, 1'b0, 2'd1}, // R10 cc1
        '{24'h4000, 24'h4000, 1'b0, 1'b0, 1'b1, 3'd0, 4'd5, 4'd6, 1'b1, 1'b1, 1'b0, 2'd2}, // R10 cc2
        '{24'h0040, 24'h0040, 1'b0, 1'b0, 1'b1, 3'd0, 4'd5, 4'd5, 1'b0, 1'b1, 1'b0, 2'd1}, // R10 guard
        '{24'h4000, 24'h4000, 1'b0, 1'b0, 1'b1, 3'd0, 4'd0, 4'd3, 1'b1, 1'b1, 1'b0, 2'd0}  // R10 key 0
    };

    task automatic chk(input string tag, input int vi, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s vec %0d act=%0d exp=%0d", tag, vi, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            failures++;
            $display("FAIL R1 watchdog act=%0d exp=done", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        // R2 reset held
        repeat (3) @(negedge clk);
        chk("R2 ready in reset", -1, {1'b0, req_ready}, 2'd1);
        chk("R2 valid in reset", -1, {1'b0, rsp_valid}, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 ready after reset", -1, {1'b0, req_ready}, 2'd1);
        chk("R2 flags after reset", -1, {rsp_allow | rsp_prot_exc | rsp_test, rsp_valid}, 2'd0);
        chk("R2 cc after reset", -1, rsp_cc, 2'd0);

        for (int i = 0; i < NV; i++) begin
            req_laddr = VT[i].la;  req_paddr = VT[i].pa;  req_virt = VT[i].virt;
            req_store = VT[i].st;  req_test = VT[i].tst;  req_src = VT[i].src;
            acc_key = VT[i].ak;    stor_key = VT[i].sk;   fetch_prot = VT[i].fp;
            ctl_lowprot_en = VT[i].en;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R1 rsp_valid", i, {1'b0, rsp_valid}, 2'd1);
            chk("R1 ready low", i, {1'b0, req_ready}, 2'd0);
            if (VT[i].tst) begin
                chk("R10 cc", i, rsp_cc, VT[i].ex_cc);
                chk("R10 flags clear", i, {rsp_allow, rsp_prot_exc}, 2'd0);
                chk("R10 rsp_test", i, {1'b0, rsp_test}, 2'd1);
            end else begin
                chk("R3/R4 allow,exc (R11)", i, {rsp_allow, rsp_prot_exc}, {VT[i].ex_allow, ~VT[i].ex_allow});
                chk("R11 cc zero", i, rsp_cc, 2'd0);
            end
            @(negedge clk);
            chk("R1 strobe dropped", i, {1'b0, rsp_valid}, 2'd0);
            chk("R1 ready back", i, {1'b0, req_ready}, 2'd1);
        end

        // R1 request held high: second request accepted only after return to idle
        req_test = 1'b0; req_store = 1'b0; acc_key = 4'd1; stor_key = 4'd1; fetch_prot = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        chk("R1 held: first rsp", 100, {1'b0, rsp_valid}, 2'd1);
        @(negedge clk);
        chk("R1 held: gap cycle", 101, {rsp_valid, req_ready}, 2'd1);
        @(negedge clk);
        chk("R1 held: second rsp", 102, {rsp_valid, rsp_allow}, 2'd3);
        req_valid = 1'b0;
        @(negedge clk);

        // R2 asynchronous reset during a response
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 rsp before reset", 200, {1'b0, rsp_valid}, 2'd1);
        rst_n = 1'b0;
        #1;
        chk("R2 async clear", 200, {rsp_valid, rsp_allow}, 2'd0);
        chk("R2 ready in reset", 200, {1'b0, req_ready}, 2'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle after reset", 201, {rsp_valid, req_ready}, 2'd1);

        summary();
        $finish;
    end
endmodule